// File: doc/BRIEF.md
# Serial Register Front End for a Multi-Channel LED Driver

This block is the control port of an LED driver. A host talks to it over a four-wire serial link using clock polarity 0 and phase 0. Every transaction opens with a low-going chip select. The first byte that follows is a command: its top bit picks a read (1) or a write (0), and its low seven bits give the starting register address. Each later byte is written to, or read from, the current address, and the address then steps forward by one. The serial lines are oversampled by the system clock, so the whole block lives in one clock domain.

Brightness, current scaling and blink settings are written into staging copies. The outputs that feed the drive logic only change when the host writes 00h to one of two commit addresses: one commits the scaling bank, the other commits the PWM and blink bank. Open-LED status bytes are latched from per-channel flags and clear on read. A key value written to a reset address restores every register default. A global enable bit and a hardware run input together gate the channel drivers. A rising edge on the hardware run input aborts the serial engine and keeps all register contents.

Top module: `led_spi_regbank`

## Requirements
- R1: Bits are captured on the rising edge of SCK, MSB first, while chip select is low. The falling edge of chip select starts a transaction. The first byte is a command: bit 7 = 1 means read, and bits 6:0 are the start address, so read command = address + 80h.
- R2: After each complete data byte, the address pointer advances by one. This holds for reads and writes alike, for as long as chip select stays low.
- R3: MISO shifts data out MSB first and changes only after a falling SCK edge. The first bit is valid before the first rising edge of the data byte. The output enable is low while chip select is high.
- R4: Scaling registers 02h–13h (one per channel) write to staging. The active scaling outputs load from staging only when 00h is written to 36h. Any other value written to 36h has no effect.
- R5: The following registers write to staging: PWM 1Fh–30h, blink enables 31h–33h, blink rate 34h and blink duty 35h. Their outputs load only when 00h is written to 37h.
- R6: Reads of a staged address return the staging copy, not the active copy.
- R7: Writing AEh to 3Fh restores all defaults: 00h=00h, 01h=3Fh, scaling FFh (staged and active), 14h=03h, and every other register 00h. Any other value written to 3Fh is ignored.
- R8: Status bytes 15h–17h hold an open flag per channel. Each byte covers six channels: channel 6g+k sits in byte g at bit k for k<3 and bit k+1 for k≥3. Flags latch only while bit 0 of 14h is 1. A read clears exactly the bits that were shifted out.
- R9: drivers_on is 1 only when bit 0 of 00h is 1 and hw_run is high. All registers stay writable and readable while this enable bit is 0.
- R10: A rising edge on hw_run ends the current transaction. SCK activity is ignored until the next falling edge of chip select. Register contents are kept.
- R11: Writes to unmapped addresses (for example 18h) are ignored, and reads of them return 00h. The commit and key addresses also read 00h. Unused bits read 0: bits 7:6 of 01h, and bits 3 and 7 of the packed blink and status bytes.
- R12: If chip select goes high in the middle of a byte, the partial byte is discarded and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| hw_run | input | 1 | Hardware run level; its rising edge aborts the serial engine |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| open_in | input | NCH | Per-channel open-LED flags |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| drivers_on | output | 1 | Channel drivers enabled |
| cfg_o | output | 8 | Configuration register |
| gcc_o | output | 6 | Global current code |
| scale_o | output | 8*NCH | Active per-channel scaling, channel 0 in the low byte |
| pwm_o | output | 8*NCH | Active per-channel duty, channel 0 in the low byte |
| blink_en_o | output | NCH | Active per-channel blink enables |
| blink_rate_o | output | 8 | Active blink rate code |
| blink_duty_o | output | 8 | Active blink duty code |

## Verification
If a staging or commit decode is wrong, an active output changes during a write that should only touch staging. The next port check shows this as soon as that transaction ends. If the address pointer or the load flag drifts, the bytes of a burst read come back shifted by one register, so the error is visible within a single data byte. A broken clear-on-read mask shows up on the second read of a status byte: either flags remain, or freshly set flags vanish. An engine that did not respond to the hardware run edge would write the bytes that follow it, and the next readback of that register would show the change.

// File: rtl/led_spi_pkg.sv
package led_spi_pkg;
  localparam int DW          = 8;
  localparam int AW          = 7;
  localparam int PACK_CH     = 6;
  localparam logic [7:0] KEY_VALUE    = 8'hAE;
  localparam logic [7:0] COMMIT_VALUE = 8'h00;
  localparam logic [7:0] PACK_MASK    = 8'h77;

  // bit position of channel k (0..5) inside a packed flag byte
  function automatic int pack_pos(input int k);
    return (k < 3) ? k : k + 1;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
      prev <= INIT;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign dout = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import led_spi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          hw_rise,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ack_en,
  output logic [AW-1:0] ack_addr,
  output logic [DW-1:0] ack_mask,
  output logic          miso,
  output logic          miso_oe
);
  logic          active, first, rd_mode, load_pend, ld_valid;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] sh_in, sh_out, ld_byte, nxt_byte;

  assign nxt_byte = {sh_in[DW-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; first <= 1'b0; rd_mode <= 1'b0;
      load_pend <= 1'b0; ld_valid <= 1'b0; bit_cnt <= '0;
      sh_in <= '0; sh_out <= '0; ld_byte <= '0; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      ack_en <= 1'b0; ack_addr <= '0; ack_mask <= '0;
      miso <= 1'b0; miso_oe <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      ack_en <= 1'b0;
      if (hw_rise || cs_s) begin
        active <= 1'b0; bit_cnt <= '0; load_pend <= 1'b0; ld_valid <= 1'b0;
      end else if (cs_fall) begin
        active <= 1'b1; first <= 1'b1; rd_mode <= 1'b0;
        bit_cnt <= '0; load_pend <= 1'b0; ld_valid <= 1'b0;
      end else if (active) begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          sh_in   <= nxt_byte;
          if (bit_cnt == 3'd7) begin
            if (first) begin
              first     <= 1'b0;
              rd_mode   <= nxt_byte[DW-1];
              ptr       <= nxt_byte[AW-1:0];
              load_pend <= nxt_byte[DW-1];
            end else begin
              if (rd_mode) begin
                ack_en    <= ld_valid;
                ack_addr  <= ptr;
                ack_mask  <= ld_byte;
                load_pend <= 1'b1;
                ld_valid  <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= nxt_byte;
              end
              ptr <= ptr + 1'b1;
            end
          end
        end else if (sck_fall) begin
          if (load_pend) begin
            miso      <= rd_data[DW-1];
            sh_out    <= {rd_data[DW-2:0], 1'b0};
            ld_byte   <= rd_data;
            ld_valid  <= 1'b1;
            load_pend <= 1'b0;
          end else begin
            miso   <= sh_out[DW-1];
            sh_out <= {sh_out[DW-2:0], 1'b0};
          end
        end
      end
      miso_oe <= active && !hw_rise && !cs_s;
    end
  end

  // R3: MISO moves only in the cycle after a falling SCK edge
  p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(miso));
  // R12: a write is only issued right after the eighth rising edge of a byte
  p_write_full_byte_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(sck_rise) && $past(bit_cnt) == 3'd7 && !$past(cs_s)));
  // R10: the hardware run edge leaves the engine idle
  p_hw_abort_r10: assert property (@(posedge clk) disable iff (rst)
    hw_rise |=> (!active && !wr_en && !miso_oe));
endmodule

// File: rtl/led_reg_store.sv
module led_reg_store
  import led_spi_pkg::*;
#(
  parameter int NCH      = 18,
  parameter int PWM_BASE = 31,
  parameter int KEY_ADDR = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             ack_en,
  input  logic [AW-1:0]    ack_addr,
  input  logic [DW-1:0]    ack_mask,
  input  logic [NCH-1:0]   open_in,
  output logic [DW-1:0]    cfg_o,
  output logic [5:0]       gcc_o,
  output logic [DW*NCH-1:0] scale_o,
  output logic [DW*NCH-1:0] pwm_o,
  output logic [NCH-1:0]   blink_en_o,
  output logic [DW-1:0]    blink_rate_o,
  output logic [DW-1:0]    blink_duty_o
);
  localparam int NGRP   = (NCH + PACK_CH - 1) / PACK_CH;
  localparam int A_CFG  = 0;
  localparam int A_GCC  = 1;
  localparam int A_SCL0 = 2;
  localparam int A_ODC  = A_SCL0 + NCH;
  localparam int A_ST0  = A_ODC + 1;
  localparam int A_PWM0 = PWM_BASE;
  localparam int A_BLK0 = A_PWM0 + NCH;
  localparam int A_RATE = A_BLK0 + NGRP;
  localparam int A_DUTY = A_RATE + 1;
  localparam int A_SCOM = A_DUTY + 1;
  localparam int A_ACOM = A_SCOM + 1;

  logic [DW-1:0] cfg;
  logic [5:0]    gcc;
  logic [1:0]    odc;
  logic [DW-1:0] scl_stg [NCH];
  logic [DW-1:0] scl_act [NCH];
  logic [DW-1:0] pwm_stg [NCH];
  logic [DW-1:0] pwm_act [NCH];
  logic [DW-1:0] blk_stg [NGRP];
  logic [DW-1:0] blk_act [NGRP];
  logic [DW-1:0] stat    [NGRP];
  logic [DW-1:0] rate_stg, rate_act, duty_stg, duty_act;
  logic [DW-1:0] set_vec [NGRP];

  int  wa;
  logic key_hit, scl_commit, act_commit;

  assign wa         = int'(wr_addr);
  assign key_hit    = wr_en && wa == KEY_ADDR && wr_data == KEY_VALUE;
  assign scl_commit = wr_en && wa == A_SCOM && wr_data == COMMIT_VALUE;
  assign act_commit = wr_en && wa == A_ACOM && wr_data == COMMIT_VALUE;

  // open flags mapped into packed status positions
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      set_vec[g] = '0;
      for (int k = 0; k < PACK_CH; k++)
        if (g * PACK_CH + k < NCH)
          set_vec[g][pack_pos(k)] = open_in[g * PACK_CH + k] & odc[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || key_hit) begin
      cfg <= '0; gcc <= 6'h3F; odc <= 2'b11;
      rate_stg <= '0; rate_act <= '0; duty_stg <= '0; duty_act <= '0;
      for (int i = 0; i < NCH; i++) begin
        scl_stg[i] <= '1; scl_act[i] <= '1; pwm_stg[i] <= '0; pwm_act[i] <= '0;
      end
      for (int g = 0; g < NGRP; g++) begin
        blk_stg[g] <= '0; blk_act[g] <= '0; stat[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        if (ack_en && int'(ack_addr) == A_ST0 + g)
          stat[g] <= (stat[g] & ~ack_mask) | set_vec[g];
        else
          stat[g] <= stat[g] | set_vec[g];
      end
      if (wr_en) begin
        if (wa == A_CFG) cfg <= wr_data;
        if (wa == A_GCC) gcc <= wr_data[5:0];
        if (wa == A_ODC) odc <= wr_data[1:0];
        if (wa == A_RATE) rate_stg <= wr_data;
        if (wa == A_DUTY) duty_stg <= wr_data;
        for (int i = 0; i < NCH; i++) begin
          if (wa == A_SCL0 + i) scl_stg[i] <= wr_data;
          if (wa == A_PWM0 + i) pwm_stg[i] <= wr_data;
        end
        for (int g = 0; g < NGRP; g++)
          if (wa == A_BLK0 + g) blk_stg[g] <= wr_data & PACK_MASK;
      end
      if (scl_commit)
        for (int i = 0; i < NCH; i++) scl_act[i] <= scl_stg[i];
      if (act_commit) begin
        for (int i = 0; i < NCH; i++) pwm_act[i] <= pwm_stg[i];
        for (int g = 0; g < NGRP; g++) blk_act[g] <= blk_stg[g];
        rate_act <= rate_stg;
        duty_act <= duty_stg;
      end
    end
  end

  // read mux: staged copies are what the host sees
  always_comb begin
    int ra;
    ra = int'(rd_addr);
    rd_data = '0;
    if (ra == A_CFG)  rd_data = cfg;
    if (ra == A_GCC)  rd_data = {2'b00, gcc};
    if (ra == A_ODC)  rd_data = {6'b0, odc};
    if (ra == A_RATE) rd_data = rate_stg;
    if (ra == A_DUTY) rd_data = duty_stg;
    for (int i = 0; i < NCH; i++) begin
      if (ra == A_SCL0 + i) rd_data = scl_stg[i];
      if (ra == A_PWM0 + i) rd_data = pwm_stg[i];
    end
    for (int g = 0; g < NGRP; g++) begin
      if (ra == A_ST0 + g)  rd_data = stat[g];
      if (ra == A_BLK0 + g) rd_data = blk_stg[g];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_flat
    assign scale_o[i*DW +: DW] = scl_act[i];
    assign pwm_o[i*DW +: DW]   = pwm_act[i];
    assign blink_en_o[i]       = blk_act[i / PACK_CH][pack_pos(i % PACK_CH)];
  end

  assign cfg_o        = cfg;
  assign gcc_o        = gcc;
  assign blink_rate_o = rate_act;
  assign blink_duty_o = duty_act;

  // R4: active scaling moves only on its commit or on the reset key
  p_scale_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(scl_commit || key_hit) |=> $stable(scale_o));
  // R5: active PWM and blink move only on their commit or on the reset key
  p_pwm_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(act_commit || key_hit) |=> ($stable(pwm_o) && $stable(blink_en_o)
                                  && $stable(blink_rate_o) && $stable(blink_duty_o)));
  for (genvar g = 0; g < NGRP; g++) begin : g_stat_chk
    // R8: with detection off, the bits just read are cleared
    p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (ack_en && int'(ack_addr) == A_ST0 + g && !odc[0] && !key_hit)
        |=> ((stat[g] & $past(ack_mask)) == '0));
    // R11: unused packed positions never set
    p_stat_unused_r11: assert property (@(posedge clk) disable iff (rst)
      (stat[g] & ~PACK_MASK) == '0);
  end
endmodule

// File: rtl/led_spi_regbank.sv
module led_spi_regbank
  import led_spi_pkg::*;
#(
  parameter int NCH         = 18,
  parameter int SYNC_STAGES = 2,
  parameter int PWM_BASE    = 31,
  parameter int KEY_ADDR    = 63
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_run,
  input  logic               spi_cs_n,
  input  logic               spi_sck,
  input  logic               spi_mosi,
  input  logic [NCH-1:0]     open_in,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  output logic               drivers_on,
  output logic [7:0]         cfg_o,
  output logic [5:0]         gcc_o,
  output logic [8*NCH-1:0]   scale_o,
  output logic [8*NCH-1:0]   pwm_o,
  output logic [NCH-1:0]     blink_en_o,
  output logic [7:0]         blink_rate_o,
  output logic [7:0]         blink_duty_o
);
  localparam int IDX_CS = 0, IDX_SCK = 1, IDX_MOSI = 2, IDX_HW = 3;

  logic [3:0] s_lvl, s_rise, s_fall;
  logic [AW-1:0] ptr, wr_addr, ack_addr;
  logic [DW-1:0] rd_data, wr_data, ack_mask;
  logic wr_en, ack_en;

  edge_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0001)) u_sync (
    .clk(clk), .rst(rst),
    .din({hw_run, spi_mosi, spi_sck, spi_cs_n}),
    .dout(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst(rst),
    .cs_s(s_lvl[IDX_CS]), .cs_fall(s_fall[IDX_CS]),
    .sck_rise(s_rise[IDX_SCK]), .sck_fall(s_fall[IDX_SCK]),
    .mosi_s(s_lvl[IDX_MOSI]), .hw_rise(s_rise[IDX_HW]),
    .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_en(ack_en), .ack_addr(ack_addr), .ack_mask(ack_mask),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  led_reg_store #(.NCH(NCH), .PWM_BASE(PWM_BASE), .KEY_ADDR(KEY_ADDR)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data),
    .ack_en(ack_en), .ack_addr(ack_addr), .ack_mask(ack_mask),
    .open_in(open_in),
    .cfg_o(cfg_o), .gcc_o(gcc_o), .scale_o(scale_o), .pwm_o(pwm_o),
    .blink_en_o(blink_en_o), .blink_rate_o(blink_rate_o), .blink_duty_o(blink_duty_o)
  );

  always_ff @(posedge clk) begin
    if (rst) drivers_on <= 1'b0;
    else     drivers_on <= cfg_o[0] & s_lvl[IDX_HW];
  end

  // R9: drivers stay off while the hardware run level is low
  p_drive_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !s_lvl[IDX_HW] |=> !drivers_on);
endmodule

// File: tb/led_spi_regbank_test.sv
module led_spi_regbank_test;
  localparam int NCH  = 18;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, hw_run = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [NCH-1:0] open_in = '0;
  logic miso, miso_oe, drivers_on;
  logic [7:0] cfg_o, blink_rate_o, blink_duty_o;
  logic [5:0] gcc_o;
  logic [8*NCH-1:0] scale_o, pwm_o;
  logic [NCH-1:0] blink_en_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  led_spi_regbank #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .hw_run(hw_run), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .open_in(open_in), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .drivers_on(drivers_on), .cfg_o(cfg_o), .gcc_o(gcc_o), .scale_o(scale_o),
    .pwm_o(pwm_o), .blink_en_o(blink_en_o), .blink_rate_o(blink_rate_o),
    .blink_duty_o(blink_duty_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  task automatic cs_on();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_off();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_on(); xfer({1'b0, a}, r); xfer(d, r); cs_off();
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_on(); xfer({1'b1, a}, r); xfer(8'h00, d); cs_off();
  endtask

  task automatic t_reset();
    chk("R7 reset cfg", cfg_o, 8'h00);
    chk("R7 reset gcc", gcc_o, 6'h3F);
    chk("R7 reset scale", scale_o[7:0], 8'hFF);
    chk("R3 oe low idle", miso_oe, 1'b0);
    chk("R9 drivers off", drivers_on, 1'b0);
  endtask

  task automatic t_shutdown_access();
    logic [7:0] d;
    wr1(7'h01, 8'hFF);
    chk("R9 write during shutdown", gcc_o, 6'h3F);
    wr1(7'h01, 8'h25);
    rd1(7'h01, d);
    chk("R1 readback gcc", d, 8'h25);
    wr1(7'h00, 8'h01);
    chk("R9 drivers on", drivers_on, 1'b1);
    hw_run = 1'b0; wait_clk(8);
    chk("R9 hw low gates drivers", drivers_on, 1'b0);
    hw_run = 1'b1; wait_clk(8);
  endtask

  task automatic t_scaling();
    logic [7:0] r, d;
    cs_on(); xfer(8'h02, r); xfer(8'h80, r); xfer(8'h81, r); cs_off();
    chk("R4 scale staged", scale_o[15:0], 16'hFFFF);
    rd1(7'h03, d);
    chk("R2 R6 staged ch1", d, 8'h81);
    wr1(7'h36, 8'h01);
    chk("R4 wrong commit value", scale_o[15:0], 16'hFFFF);
    wr1(7'h36, 8'h00);
    chk("R4 commit", scale_o[15:0], 16'h8180);
  endtask

  task automatic t_pwm_blink();
    logic [7:0] r, d;
    cs_on(); xfer(8'h1F, r); xfer(8'h44, r); xfer(8'h55, r); cs_off();
    cs_on(); xfer(8'h31, r); xfer(8'hFF, r); xfer(8'h01, r); xfer(8'h00, r);
    xfer(8'h10, r); xfer(8'h80, r); cs_off();
    chk("R5 pwm staged", pwm_o[15:0], 16'h0000);
    chk("R5 blink staged", blink_en_o, 18'h0);
    rd1(7'h31, d);
    chk("R11 R6 blink masked", d, 8'h77);
    wr1(7'h37, 8'h05);
    chk("R5 wrong commit", blink_rate_o, 8'h00);
    wr1(7'h37, 8'h00);
    chk("R5 pwm commit", pwm_o[15:0], 16'h5544);
    chk("R5 blink commit", blink_en_o, 18'h0007F);
    chk("R5 rate duty", {blink_rate_o, blink_duty_o}, 16'h1080);
  endtask

  task automatic t_burst_read();
    logic [7:0] r, d0, d1, d2;
    cs_on(); xfer(8'h81, r); xfer(8'h00, d0); xfer(8'h00, d1); xfer(8'h00, d2); cs_off();
    chk("R2 R3 burst byte0", d0, 8'h25);
    chk("R2 burst byte1", d1, 8'h80);
    chk("R2 burst byte2", d2, 8'h81);
  endtask

  task automatic t_status();
    logic [7:0] r, d0, d1, d2;
    open_in = 18'h20009; wait_clk(4); open_in = '0; wait_clk(4);
    cs_on(); xfer(8'h95, r); xfer(8'h00, d0); xfer(8'h00, d1); xfer(8'h00, d2); cs_off();
    chk("R8 status byte0", d0, 8'h11);
    chk("R8 status byte1", d1, 8'h00);
    chk("R8 status byte2", d2, 8'h40);
    rd1(7'h15, d0);
    chk("R8 cleared on read", d0, 8'h00);
    wr1(7'h14, 8'h00);
    open_in = 18'h00001; wait_clk(8); open_in = '0;
    rd1(7'h15, d0);
    chk("R8 detect disabled", d0, 8'h00);
    wr1(7'h14, 8'h03);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr1(7'h18, 8'h55);
    rd1(7'h18, d);
    chk("R11 unmapped reads zero", d, 8'h00);
    rd1(7'h36, d);
    chk("R11 commit addr reads zero", d, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] r, d;
    cs_on(); xfer(8'h01, r); send_bits(8'h0A, 4, r); cs_off();
    chk("R12 partial byte dropped", gcc_o, 6'h25);
    cs_on(); xfer(8'h01, r);
    hw_run = 1'b0; wait_clk(6); hw_run = 1'b1; wait_clk(6);
    xfer(8'h07, r); cs_off();
    chk("R10 engine reset drops write", gcc_o, 6'h25);
    chk("R10 contents kept", cfg_o, 8'h01);
    rd1(7'h01, d);
    chk("R10 new frame works", d, 8'h25);
    chk("R3 oe low after frame", miso_oe, 1'b0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr1(7'h3F, 8'h12);
    chk("R7 wrong key ignored", gcc_o, 6'h25);
    wr1(7'h3F, 8'hAE);
    chk("R7 key gcc", gcc_o, 6'h3F);
    chk("R7 key cfg", cfg_o, 8'h00);
    chk("R7 key scale", scale_o[15:0], 16'hFFFF);
    chk("R7 key pwm blink", {pwm_o[15:0], blink_en_o}, 34'h0);
    rd1(7'h14, d);
    chk("R7 detect ctrl default", d, 8'h03);
  endtask

  initial begin
    wait_clk(200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(10);
    t_reset();
    t_shutdown_access();
    t_scaling();
    t_pwm_blink();
    t_burst_read();
    t_status();
    t_unmapped();
    t_abort();
    t_soft_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule